// File: doc/BRIEF.md
# Accumulator Processor Core

A small stored-program processor built around one 16-bit accumulator. It reads instructions and operands from a single external synchronous memory through a 12-bit address bus and a 16-bit split data bus (separate read and write lanes). It also drives a request strobe and a read/not-write line. Each instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit operand address S in bits 11:0.

The core alternates between an execute step and a fetch step. One adder/selector serves both steps. In the execute step it computes the accumulator result. In the fetch step it produces the fetch address plus one, which becomes the new program counter. Every instruction costs exactly one cycle per memory access. The memory must return read data combinationally in the cycle of the request. A stop instruction freezes the core and raises a halted flag, which stays set until the next reset.

Top module: `accum_core`

## Requirements
- R1: While reset is low at a clock edge, the program counter is cleared. In the first cycle after reset, the core reads (mem_rnw=1, mem_req=1) address 0x000, and halted is low.
- R2: Opcode 0000 (load) reads memory[S] in its execute cycle and writes that word into the accumulator.
- R3: Opcode 0010 adds memory[S] to the accumulator, and opcode 0011 subtracts memory[S] from it. Both results wrap modulo 2^16, and no flags are kept.
- R4: Opcode 0001 (store) performs one write cycle: mem_rnw=0, mem_addr=S, mem_wdata equal to the accumulator. The accumulator is left unchanged. mem_rnw is low in no other cycle.
- R5: Load, store, add and subtract take two cycles each: the execute access at S, then a fetch from the PC. Every fetch loads the instruction register and sets PC to the fetch address plus one.
- R6: Opcode 0100 (jump) takes one cycle. That cycle fetches the next instruction directly from S and sets PC to S+1.
- R7: Opcode 0101 jumps to S exactly when accumulator bit 15 is 0.
- R8: Opcode 0110 jumps to S exactly when the accumulator is non-zero. A conditional jump that is not taken takes one cycle, fetching sequentially from the PC.
- R9: Opcode 0111 (stop) raises halted at the end of its execute cycle. After that, mem_req stays low and PC and accumulator are frozen until the next reset.
- R10: Opcodes 1000 to 1111 behave exactly like stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address for the current access |
| mem_rdata | input | 16 | Read data, valid in the cycle of the request |
| mem_wdata | output | 16 | Write data (accumulator on stores, zero otherwise) |
| mem_req | output | 1 | Memory access request |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| halted | output | 1 | Core has executed a stop or undefined opcode |

## Verification
Some properties are checked by assertions on every cycle:
- a write never happens without a request, and the accumulator holds across a write;
- every fetch leaves the PC one above the fetch address;
- halted is sticky and silences the memory port while PC and accumulator stay frozen;
- reset clears the PC.

Other behaviour can only be shown by the bench's small programs, which check memory contents and cycle totals:
- arithmetic wrap-around;
- which branch direction is taken for negative, zero and positive accumulators;
- the exact cycle cost of each instruction kind;
- undefined opcodes stopping the core.

// File: rtl/accum_core_pkg.sv
// Package: shared opcode, ALU function and control-word types for the
// accumulator core. Assumes a 4-bit opcode in the top bits of each word.
package accum_core_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_STORE = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_JUMP  = 4'd4,
        OP_JPOS  = 4'd5,
        OP_JNZ   = 4'd6,
        OP_STOP  = 4'd7
    } opcode_e;

    typedef enum logic [2:0] {
        FN_ZERO,
        FN_PASS_B,
        FN_INC_B,
        FN_ADD,
        FN_SUB
    } alu_fn_e;

    typedef struct packed {
        logic    addr_from_ir;  // address bus from IR operand, else PC
        logic    b_from_mem;    // ALU B operand from read data, else address
        logic    acc_we;
        logic    pc_we;
        logic    ir_we;
        logic    acc_oe;
        alu_fn_e alu_fn;
        logic    mem_req;
        logic    mem_rnw;
        logic    exec_next;     // value of execute/fetch flag after this cycle
        logic    halt_set;
    } ctrl_t;

endpackage

// File: rtl/accum_core_alu.sv
// ALU shared by execute and fetch steps. Purely combinational.
// Assumes modulo-2^W arithmetic; no carry or overflow is produced.
module accum_core_alu
    import accum_core_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  alu_fn_e      fn,
    output logic [W-1:0] y
);

    // Select the requested function.
    always_comb begin
        unique case (fn)
            FN_PASS_B: y = b_in;
            FN_INC_B:  y = b_in + W'(1);
            FN_ADD:    y = a_in + b_in;
            FN_SUB:    y = a_in - b_in;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/accum_core_ctrl.sv
// Hardwired control: decodes the phase flag, opcode and accumulator tests
// into one control word per cycle. Assumes memory reads complete in the
// requesting cycle. During reset it selects a zero ALU result into the PC.
module accum_core_ctrl
    import accum_core_pkg::*;
(
    input  logic             rst_n,
    input  logic             exec_q,
    input  logic             halted_q,
    input  logic [OPC_W-1:0] opcode,
    input  logic             acc_neg,
    input  logic             acc_zero,
    output ctrl_t            ctl
);

    // Fetch-step control word; take_s picks S instead of the PC as address.
    function automatic ctrl_t fetch_word(input logic take_s);
        ctrl_t f;
        f              = '0;
        f.alu_fn       = FN_INC_B;
        f.mem_rnw      = 1'b1;
        f.mem_req      = 1'b1;
        f.ir_we        = 1'b1;
        f.pc_we        = 1'b1;
        f.exec_next    = 1'b1;
        f.addr_from_ir = take_s;
        return f;
    endfunction

    // Decode the current cycle.
    always_comb begin
        ctl         = '0;
        ctl.alu_fn  = FN_ZERO;
        ctl.mem_rnw = 1'b1;
        if (!rst_n) begin
            ctl.pc_we = 1'b1;
        end else if (halted_q) begin
            ctl.mem_req = 1'b0;
        end else if (!exec_q) begin
            ctl = fetch_word(1'b0);
        end else begin
            unique case (opcode)
                OP_LOAD, OP_ADD, OP_SUB: begin
                    ctl.mem_req      = 1'b1;
                    ctl.addr_from_ir = 1'b1;
                    ctl.b_from_mem   = 1'b1;
                    ctl.acc_we       = 1'b1;
                    ctl.alu_fn       = (opcode == OP_LOAD) ? FN_PASS_B :
                                       (opcode == OP_ADD)  ? FN_ADD : FN_SUB;
                end
                OP_STORE: begin
                    ctl.mem_req      = 1'b1;
                    ctl.mem_rnw      = 1'b0;
                    ctl.addr_from_ir = 1'b1;
                    ctl.acc_oe       = 1'b1;
                end
                OP_JUMP: ctl = fetch_word(1'b1);
                OP_JPOS: ctl = fetch_word(!acc_neg);
                OP_JNZ:  ctl = fetch_word(!acc_zero);
                default: ctl.halt_set = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/accum_core_chk.sv
// Checker for the accumulator core, attached by bind below.
module accum_core_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_req,
    input logic              mem_rnw,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic              ir_load
);

    // R1: reset clears the PC.
    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> pc == '0);

    // R4: writes only occur with a request.
    assert_write_has_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rnw |-> mem_req);

    // R4: accumulator unchanged by a store.
    assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rnw) |=> $stable(acc));

    // R5 / R6: each fetch leaves the PC one above the fetch address.
    assert_fetch_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> pc == $past(mem_addr) + ADDR_W'(1));

    // R9: halted is sticky until reset.
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R9: halted core issues no memory requests.
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R9: halted core keeps PC and accumulator frozen.
    assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && $stable(acc)));

endmodule

bind accum_core accum_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_addr(mem_addr),
    .mem_req (mem_req),
    .mem_rnw (mem_rnw),
    .halted  (halted),
    .pc      (pc_q),
    .acc     (acc_q),
    .ir_load (ir_load)
);

// File: rtl/accum_core.sv
// Accumulator processor top: PC, IR, accumulator, phase flag and halt flag,
// with the address and ALU B-operand multiplexers. Assumes a memory with
// combinational read data and a write on the clock edge of a write request.
module accum_core
    import accum_core_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic [ADDR_W+OPC_W-1:0]   mem_rdata,
    output logic [ADDR_W+OPC_W-1:0]   mem_wdata,
    output logic                      mem_req,
    output logic                      mem_rnw,
    output logic                      halted
);

    localparam int DATA_W = ADDR_W + OPC_W;

    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic              exec_q;
    logic              halted_q;
    ctrl_t             ctl;
    logic              ir_load;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;

    accum_core_ctrl ctrl_i (
        .rst_n   (rst_n),
        .exec_q  (exec_q),
        .halted_q(halted_q),
        .opcode  (ir_q[DATA_W-1 -: OPC_W]),
        .acc_neg (acc_q[DATA_W-1]),
        .acc_zero(acc_q == '0),
        .ctl     (ctl)
    );

    // Address and B-operand multiplexers.
    always_comb begin
        mem_addr = ctl.addr_from_ir ? ir_q[ADDR_W-1:0] : pc_q;
        alu_b    = ctl.b_from_mem ? mem_rdata : {{OPC_W{1'b0}}, mem_addr};
    end

    accum_core_alu #(.W(DATA_W)) alu_i (
        .a_in(acc_q),
        .b_in(alu_b),
        .fn  (ctl.alu_fn),
        .y   (alu_y)
    );

    assign ir_load   = ctl.ir_we;
    assign mem_req   = ctl.mem_req;
    assign mem_rnw   = ctl.mem_rnw;
    assign mem_wdata = ctl.acc_oe ? acc_q : '0;
    assign halted    = halted_q;

    // PC takes the ALU result (zero during reset, address+1 on fetch).
    always_ff @(posedge clk) begin
        if (ctl.pc_we) pc_q <= alu_y[ADDR_W-1:0];
    end

    // Instruction register loads on every fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)       ir_q <= '0;
        else if (ir_load) ir_q <= mem_rdata;
    end

    // Accumulator loads the ALU result on load/add/sub.
    always_ff @(posedge clk) begin
        if (!rst_n)          acc_q <= '0;
        else if (ctl.acc_we) acc_q <= alu_y;
    end

    // Execute/fetch flag advances with each memory access.
    always_ff @(posedge clk) begin
        if (!rst_n)           exec_q <= 1'b0;
        else if (ctl.mem_req) exec_q <= ctl.exec_next;
    end

    // Halt flag is set by stop or undefined opcodes, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)            halted_q <= 1'b0;
        else if (ctl.halt_set) halted_q <= 1'b1;
    end

endmodule

// File: tb/accum_core_tb_top.sv
// Directed bench: each task loads a program, runs it to halt and checks
// memory results, cycle counts and port behaviour.
module accum_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_req;
    logic        mem_rnw;
    logic        halted;

    logic [15:0] mem [MEM_WORDS];
    int          wr_count = 0;
    int          n_checks = 0;
    int          n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    accum_core dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata),
        .mem_req  (mem_req),
        .mem_rnw  (mem_rnw),
        .halted   (halted)
    );

    assign mem_rdata = mem[mem_addr[8:0]];

    // Behavioural RAM write port.
    always @(posedge clk) begin
        if (rst_n && mem_req && !mem_rnw) begin
            mem[mem_addr[8:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] s);
        return {op, s};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h7000;
        for (int i = 9'h180; i < 9'h190; i++) mem[i] = 16'hDEAD;
    endtask

    // Reset, then check the first post-reset cycle (R1).
    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(mem_addr == 12'h000, "R1 first fetch address", mem_addr, 0);
        check(mem_req && mem_rnw,  "R1 first access is read", {mem_req, mem_rnw}, 3);
        check(!halted,             "R1 halted low", halted, 0);
    endtask

    task automatic run_to_halt(output int n);
        n = 0;
        while (!halted && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // R2 R3 R4 R5: load, add/sub wrap, stores and two-cycle timing.
    task automatic t_arith();
        int n, w0;
        clear_mem();
        mem[0] = ins(4'h0, 12'h100); mem[1] = ins(4'h2, 12'h101);
        mem[2] = ins(4'h1, 12'h180); mem[3] = ins(4'h3, 12'h102);
        mem[4] = ins(4'h1, 12'h181); mem[5] = ins(4'h1, 12'h182);
        mem[6] = ins(4'h7, 12'h000);
        mem[9'h100] = 16'h1234; mem[9'h101] = 16'hF000; mem[9'h102] = 16'h0235;
        w0 = wr_count;
        do_reset();
        run_to_halt(n);
        check(n == 14, "R5 cycles for six data ops", n, 14);
        check(mem[9'h180] == 16'h0234, "R3 add wraps (R2 load)", mem[9'h180], 16'h0234);
        check(mem[9'h181] == 16'hFFFF, "R3 sub wraps", mem[9'h181], 16'hFFFF);
        check(mem[9'h182] == 16'hFFFF, "R4 store keeps acc", mem[9'h182], 16'hFFFF);
        check(wr_count - w0 == 3, "R4 write count", wr_count - w0, 3);
        // R9: stays halted and silent
        repeat (4) begin
            @(negedge clk);
            check(halted && !mem_req, "R9 halted and quiet", {halted, mem_req}, 2);
        end
        check(wr_count - w0 == 3, "R9 no writes after halt", wr_count - w0, 3);
    endtask

    // R6: unconditional jump skips a store, costs one cycle.
    task automatic t_jump();
        int n;
        clear_mem();
        mem[0] = ins(4'h0, 12'h100); mem[1] = ins(4'h4, 12'h004);
        mem[2] = ins(4'h1, 12'h180); mem[3] = ins(4'h7, 12'h000);
        mem[4] = ins(4'h1, 12'h181); mem[5] = ins(4'h7, 12'h000);
        mem[9'h100] = 16'h0005;
        do_reset();
        run_to_halt(n);
        check(n == 7, "R6 jump cycles", n, 7);
        check(mem[9'h180] == 16'hDEAD, "R6 skipped store", mem[9'h180], 16'hDEAD);
        check(mem[9'h181] == 16'h0005, "R6 target store", mem[9'h181], 5);
    endtask

    // R7 R8: conditional jumps on negative and zero accumulators.
    task automatic t_cond();
        int n;
        clear_mem();
        mem[0]  = ins(4'h0, 12'h100); mem[1]  = ins(4'h5, 12'h005);
        mem[2]  = ins(4'h6, 12'h006);
        mem[6]  = ins(4'h1, 12'h180); mem[7]  = ins(4'h0, 12'h101);
        mem[8]  = ins(4'h6, 12'h00A); mem[9]  = ins(4'h5, 12'h00B);
        mem[11] = ins(4'h1, 12'h181);
        mem[9'h100] = 16'h8000; mem[9'h101] = 16'h0000;
        do_reset();
        run_to_halt(n);
        check(n == 14, "R8 untaken branch one cycle", n, 14);
        check(mem[9'h180] == 16'h8000, "R7 negative not taken, R8 nonzero taken", mem[9'h180], 16'h8000);
        check(mem[9'h181] == 16'h0000, "R7 zero taken, R8 zero not taken", mem[9'h181], 0);
    endtask

    // R10: undefined opcode stops the core.
    task automatic t_undef();
        int n;
        clear_mem();
        mem[0] = ins(4'h0, 12'h100); mem[1] = ins(4'h9, 12'h200);
        mem[2] = ins(4'h1, 12'h180);
        mem[9'h100] = 16'h0042;
        do_reset();
        run_to_halt(n);
        check(n == 4, "R10 undefined halts", n, 4);
        repeat (3) @(negedge clk);
        check(mem[9'h180] == 16'hDEAD, "R10 no store after undefined", mem[9'h180], 16'hDEAD);
        check(halted && !mem_req, "R10 halted quiet", {halted, mem_req}, 2);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_arith();
        t_jump();
        t_cond();
        t_undef();
        summary();
    end

endmodule